// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a management-bus master for external PHY devices. Software places an entire transaction in one 32-bit command word: a go bit, the opcode, the PHY address, the register address and, for writes, the 16-bit value. Setting the go bit starts one serial frame on the MDC clock and MDIO data line. The go bit then acts as the busy flag. Software polls it and sees it return to 0 when the frame has ended.

A read releases the data line once the address fields have been sent. The block then shifts the 16 bits returned by the PHY into a read-data register. The MDC frequency comes from the system clock through a divider whose half-period is an input. MDC rests low whenever no frame is running. The data line is modelled as three separate pins (input, output and output enable), so that a pad or a tristate buffer can be placed outside the block.

Top module: `mdio_frame_master`

## Requirements
- R1: Command word fields: bits 4:0 hold the register address and bits 9:5 hold the PHY address. Each field is sent MSB first, the PHY address before the register address.
- R2: A frame is 64 MDC periods, one bit per period, in this order: 32 preamble ones, 2 start bits, 2 opcode bits (command bits 11:10), the PHY address, the register address, 2 turnaround bits, then 16 data bits MSB first. The data line is driven only while a frame runs.
- R3: Command bit 12 selects the start pattern. When bit 12 is 1 the start bits are 01; when it is 0 they are 00.
- R4: Opcode 01 is a write. The master drives turnaround 10 and then sends command bits 31:16 as the data.
- R5: Writing the command word with bit 15 (go) set starts a frame. Bit 15 reads back as 1 for the whole frame and returns to 0 when the frame ends. A word written with bit 15 at 0 is stored but starts no frame, and MDC stays low.
- R6: Opcode 10 is a read. The output enable is low for the two turnaround bits and the 16 data bits. The value sampled from the line during the data bits appears on the read-data output, MSB first, when the frame ends.
- R7: When no PHY answers, the line floats high and a read returns 0xFFFF.
- R8: Each MDC half-period lasts `mdc_half` system clocks, and 0 is treated as 1. MDC is low between frames. The data output changes only on a falling MDC edge, and read data is sampled on the rising edge.
- R9: A command write that arrives while bit 15 is still set is ignored. The stored word and the running frame are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Stored command word; bit 15 is the busy/go flag |
| mii_rdata | output | 16 | Result of the last completed read |
| mdc_half | input | DIV_W | MDC half-period in system clocks |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data value to drive |
| mdio_oe | output | 1 | Drive enable for the data line |

## Verification
A table of command words is run through a behavioural PHY that records every bit seen on a rising MDC edge. It also records whether the master was driving at that moment. The table covers writes with all-zero, all-one and mixed address and data fields, both start patterns, reads from a responding PHY with alternating and sparse bit patterns, and a read with no PHY present. This separates a swapped address field, a wrong start pattern, a missing release of the line and a bit-order error in the captured data. Directed tests cover a go-less write, a write while the block is busy, and two divider settings including zero; the divider tests measure the MDC period in system clocks.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

   typedef struct packed {
      logic [15:0] wdata;
      logic        go;
      logic [1:0]  spare;
      logic        cl22;
      logic [1:0]  op;
      logic [4:0]  phy;
      logic [4:0]  regad;
   } mfc_cmd_t;

   localparam logic [1:0] OP_WR = 2'b01;
   localparam logic [1:0] OP_RD = 2'b10;
   localparam logic [1:0] TA_DRIVEN = 2'b10;

endpackage

// File: rtl/mfc_mdc_gen.sv
module mfc_mdc_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half_cyc,
   output logic             mdc,
   output logic             rise_stb,
   output logic             fall_stb
);

   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("mfc_mdc_gen: DIV_W out of range");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;
   logic             wrap;

   assign lim      = (half_cyc == '0) ? '0 : half_cyc - DIV_W'(1);
   assign wrap     = run && (cnt_q == lim);
   assign rise_stb = wrap && !mdc;
   assign fall_stb = wrap && mdc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         mdc   <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc   <= !mdc;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !mdc); // R8
   AST_MDC_MOVES_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !rise_stb && !fall_stb) |=> $stable(mdc)); // R8

endmodule

// File: rtl/mfc_frame_seq.sv
module mfc_frame_seq #(
   parameter int PRE_BITS = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                rd_mode,
   input  logic [PRE_BITS+31:0] frame,
   input  logic                rise_stb,
   input  logic                fall_stb,
   input  logic                mdio_i,
   output logic                active,
   output logic                mdio_o,
   output logic                mdio_oe,
   output logic                done,
   output logic [15:0]         rd_data
);

   localparam int FRAME_BITS = PRE_BITS + 32;
   localparam int CNT_W      = $clog2(FRAME_BITS + 1);
   localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] TA_POS  = CNT_W'(PRE_BITS + 14);
   localparam logic [CNT_W-1:0] DAT_POS = CNT_W'(PRE_BITS + 16);

   logic [FRAME_BITS-1:0] sh_q;
   logic [CNT_W-1:0]      bit_q;
   logic                  act_q;
   logic                  rd_q;
   logic [15:0]           cap_q;
   logic                  in_ta;
   logic                  in_data;

   assign in_ta   = bit_q >= TA_POS;
   assign in_data = bit_q >= DAT_POS;
   assign done    = act_q && fall_stb && (bit_q == LAST);
   assign active  = act_q;
   assign mdio_o  = act_q && sh_q[FRAME_BITS-1];
   assign mdio_oe = act_q && !(rd_q && in_ta);
   assign rd_data = cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         rd_q  <= 1'b0;
         bit_q <= '0;
         sh_q  <= '0;
      end else if (start && !act_q) begin
         act_q <= 1'b1;
         rd_q  <= rd_mode;
         bit_q <= '0;
         sh_q  <= frame;
      end else if (act_q && fall_stb) begin
         if (bit_q == LAST) begin
            act_q <= 1'b0;
         end else begin
            bit_q <= bit_q + CNT_W'(1);
            sh_q  <= {sh_q[FRAME_BITS-2:0], 1'b0};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (act_q && rd_q && in_data && rise_stb) begin
         cap_q <= {cap_q[14:0], mdio_i};
      end
   end

   AST_LINE_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !fall_stb) |=> $stable(mdio_o)); // R8
   AST_RELEASE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !mdio_oe) |-> rd_q); // R6
   AST_BIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_q <= LAST); // R2

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
   import mfc_pkg::*;
#(
   parameter int PRE_BITS = 32,
   parameter int DIV_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [31:0]      cmd_wdata,
   output logic [31:0]      cmd_rdata,
   output logic [15:0]      mii_rdata,
   input  logic [DIV_W-1:0] mdc_half,
   output logic             mdc,
   input  logic             mdio_i,
   output logic             mdio_o,
   output logic             mdio_oe
);

   generate
      if (PRE_BITS < 1 || PRE_BITS > 64) begin : g_bad_pre
         $error("mdio_frame_master: PRE_BITS out of range");
      end
   endgenerate

   localparam int FRAME_BITS = PRE_BITS + 32;

   mfc_cmd_t              w_cmd;
   mfc_cmd_t              cmd_q;
   logic [31:0]           cmd_vec;
   logic [15:0]           rdat_q;
   logic [FRAME_BITS-1:0] frame;
   logic [1:0]            start_bits;
   logic                  start;
   logic                  seq_active;
   logic                  seq_done;
   logic [15:0]           seq_rdata;
   logic                  rise_stb;
   logic                  fall_stb;

   assign w_cmd      = mfc_cmd_t'(cmd_wdata);
   assign cmd_vec    = cmd_q;
   assign cmd_rdata  = cmd_vec;
   assign mii_rdata  = rdat_q;
   assign start      = cmd_we && !cmd_q.go && w_cmd.go;
   assign start_bits = w_cmd.cl22 ? 2'b01 : 2'b00;
   assign frame      = {{PRE_BITS{1'b1}}, start_bits, w_cmd.op, w_cmd.phy,
                        w_cmd.regad, TA_DRIVEN, w_cmd.wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (cmd_we && !cmd_q.go) begin
         cmd_q <= w_cmd;
      end else if (seq_done) begin
         cmd_q.go <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdat_q <= '0;
      end else if (seq_done && cmd_q.op == OP_RD) begin
         rdat_q <= seq_rdata;
      end
   end

   mfc_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (seq_active),
      .half_cyc (mdc_half),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mfc_frame_seq #(.PRE_BITS(PRE_BITS)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .rd_mode  (w_cmd.op == OP_RD),
      .frame    (frame),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .active   (seq_active),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .done     (seq_done),
      .rd_data  (seq_rdata)
   );

   AST_BUSY_TRACKS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q.go == seq_active); // R5
   AST_GO_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |=> !cmd_q.go); // R5
   AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_q.go) |=> (cmd_vec[31:16] == $past(cmd_vec[31:16]) &&
                                cmd_vec[14:0] == $past(cmd_vec[14:0]))); // R9
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !seq_done |=> $stable(rdat_q)); // R6

endmodule

// File: tb/mdio_frame_master_tb.sv
module mdio_frame_master_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_we;
   logic [31:0] cmd_wdata;
   logic [31:0] cmd_rdata;
   logic [15:0] mii_rdata;
   logic [7:0]  mdc_half;
   logic        mdc;
   logic        mdio_i;
   logic        mdio_o;
   logic        mdio_oe;

   always #5 clk = ~clk;

   mdio_frame_master u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .mii_rdata(mii_rdata), .mdc_half(mdc_half),
      .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
   );

   // behavioural PHY: records each bit on MDC rise, answers reads after turnaround
   logic        phy_on;
   logic [15:0] phy_resp;
   logic        drv = 1'b1;
   int          rcnt = 0;
   logic [63:0] cap_bit;
   logic [63:0] cap_oe;

   assign mdio_i = mdio_oe ? mdio_o : drv;

   always @(posedge mdc) begin
      if (rcnt < 64) begin
         cap_bit[63-rcnt] = mdio_i;
         cap_oe[63-rcnt]  = mdio_oe;
      end
      rcnt = rcnt + 1;
   end

   always @(negedge mdc) begin
      drv = (phy_on && rcnt >= 48 && rcnt < 64) ? phy_resp[63-rcnt] : 1'b1;
   end

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_line(logic [31:0] c, logic [15:0] r, logic on);
      logic        rd;
      logic [15:0] d;
      logic [1:0]  ta;
      rd = (c[11:10] == 2'b10);
      d  = rd ? (on ? r : 16'hFFFF) : c[31:16];
      ta = rd ? 2'b11 : 2'b10;
      return {32'hFFFF_FFFF, (c[12] ? 2'b01 : 2'b00), c[11:10], c[9:5], c[4:0], ta, d};
   endfunction

   function automatic logic [63:0] exp_oe(logic [31:0] c);
      return (c[11:10] == 2'b10) ? 64'hFFFF_FFFF_FFFC_0000 : 64'hFFFF_FFFF_FFFF_FFFF;
   endfunction

   task automatic write_cmd(input logic [31:0] c);
      @(negedge clk);
      cmd_we    = 1'b1;
      cmd_wdata = c;
      @(negedge clk);
      cmd_we    = 1'b0;
   endtask

   task automatic wait_idle();
      while (cmd_rdata[15]) @(negedge clk);
   endtask

   task automatic run_frame(input logic [31:0] c, input logic [15:0] r, input logic on);
      phy_on   = on;
      phy_resp = r;
      rcnt     = 0;
      cap_bit  = '0;
      cap_oe   = '0;
      write_cmd(c);
      chk("R5 go reads 1 while busy", {63'd0, cmd_rdata[15]}, 64'd1);
      wait_idle();
      chk("R2 R1 R3 R4 frame bits", cap_bit, exp_line(c, r, on));
      chk("R6 drive enable pattern", cap_oe, exp_oe(c));
      chk("R5 go cleared at end", {63'd0, cmd_rdata[15]}, 64'd0);
      chk("R8 MDC low after frame", {63'd0, mdc}, 64'd0);
      if (c[11:10] == 2'b10)
         chk(on ? "R6 read data" : "R7 absent PHY reads ones",
             {48'd0, mii_rdata}, {48'd0, on ? r : 16'hFFFF});
   endtask

   // {command, PHY response, PHY present}
   localparam logic [48:0] VEC [0:7] = '{
      {32'hA5C3_9420, 16'h0000, 1'b1},
      {32'h0001_97FF, 16'h0000, 1'b1},
      {32'h0000_9843, 16'h1234, 1'b1},
      {32'h0000_9A11, 16'h8001, 1'b1},
      {32'h0000_98E2, 16'h0000, 1'b0},
      {32'h5A5A_8545, 16'h0000, 1'b1},
      {32'hDEAD_9843, 16'h0F0F, 1'b1},
      {32'h0000_9420, 16'h0000, 1'b1}
   };

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      time t0;
      rst_n     = 1'b0;
      cmd_we    = 1'b0;
      cmd_wdata = '0;
      mdc_half  = 8'd2;
      phy_on    = 1'b0;
      phy_resp  = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R5 reset command word", {32'd0, cmd_rdata}, 64'd0);
      chk("R6 reset read data", {48'd0, mii_rdata}, 64'd0);
      chk("R8 reset MDC low", {63'd0, mdc}, 64'd0);
      chk("R2 reset line released", {63'd0, mdio_oe}, 64'd0);

      // table walk
      for (int i = 0; i < 8; i++) begin
         run_frame(VEC[i][48:17], VEC[i][16:1], VEC[i][0]);
      end

      // R5: word without go bit is stored, no frame
      rcnt = 0;
      write_cmd(32'h0000_1420);
      repeat (20) @(negedge clk);
      chk("R5 go-less word stored", {32'd0, cmd_rdata}, 64'h0000_0000_0000_1420);
      chk("R5 go-less word gives no MDC edge", rcnt, 64'd0);

      // R9: write while busy is ignored
      phy_on = 1'b1; phy_resp = 16'h0000;
      rcnt = 0; cap_bit = '0; cap_oe = '0;
      write_cmd(32'hA5C3_9420);
      repeat (40) @(negedge clk);
      write_cmd(32'h1111_9843);
      @(negedge clk);
      chk("R9 busy write leaves command", {32'd0, cmd_rdata}, 64'h0000_0000_A5C3_9420);
      wait_idle();
      chk("R9 busy write leaves frame", cap_bit, exp_line(32'hA5C3_9420, 16'h0, 1'b1));

      // R8: divider setting 3 -> period of 6 clocks
      mdc_half = 8'd3;
      rcnt = 0;
      write_cmd(32'h0001_97FF);
      @(posedge mdc); t0 = $time;
      @(posedge mdc);
      chk("R8 MDC period at half=3", ($time - t0) / 10, 64'd6);
      wait_idle();
      chk("R8 frame at half=3", cap_bit, exp_line(32'h0001_97FF, 16'h0, 1'b1));

      // R8: divider setting 0 treated as 1 -> period of 2 clocks
      mdc_half = 8'd0;
      phy_resp = 16'hC3A5;
      rcnt = 0;
      write_cmd(32'h0000_9843);
      @(posedge mdc); t0 = $time;
      @(posedge mdc);
      chk("R8 MDC period at half=0", ($time - t0) / 10, 64'd2);
      wait_idle();
      chk("R6 read at half=0", {48'd0, mii_rdata}, 64'h0000_0000_0000_C3A5);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule